// File: doc/BRIEF.md
# Cartridge Bank Mapper

This block sits between an 8-bit CPU bus with a 16-bit address and two external memories: a large ROM and a RAM split into 8 KiB banks. CPU writes that land in the ROM half of the address space never reach the ROM. The block treats them as control writes and uses them to turn the external RAM on or off, to pick the ROM bank shown in the upper ROM window, and to pick either a RAM bank or a clock-register space for the external RAM window.

The block translates every CPU address into an expanded ROM address and a banked RAM address. It drives the RAM chip enable and the RAM write strobe, and it tells the surrounding data path which source to place on the read bus. The memory arrays live outside the block. The clock-register space has no counter behind it: reads from it return zero and writes to it are dropped. An unsupported select value raises a one-cycle error flag.

Top module: `bank_mapper`

## Requirements
- R1: After reset the ROM bank is 0, the RAM bank is 0, the clock space is deselected, external RAM is disabled and `sel_err` is 0.
- R2: Addresses 0x0000–0x3FFF map to ROM address `{0, addr[13:0]}`, whatever the ROM bank.
- R3: Addresses 0x4000–0x7FFF map to ROM address `rom_bank * 0x4000 + addr[13:0]`. Bank 0 is not remapped.
- R4: A write of 0x0A to 0x0000–0x1FFF enables external RAM. A write of 0x00 there disables it. Any other value leaves the enable unchanged.
- R5: A write to 0x2000–0x3FFF loads the ROM bank with `data & 0x7F`. The bank changes only on such a write.
- R6: A write of 0x00–0x03 to 0x4000–0x5FFF selects that RAM bank and leaves the clock space. RAM address = `bank * 0x2000 + addr[12:0]`.
- R7: A write of 0x08–0x0C to 0x4000–0x5FFF selects the clock space. While RAM is enabled, reads in 0xA000–0xBFFF then select zero data, and `ram_ce` and `ram_we` stay low.
- R8: Any other value written to 0x4000–0x5FFF leaves the select unchanged and drives `sel_err` high for exactly the one cycle after that clock edge.
- R9: Writes to 0x6000–0x7FFF change no state.
- R10: While RAM is disabled, reads in 0xA000–0xBFFF select 0xFF data and no RAM write strobe is issued.
- R11: `rd_sel` encoding: 0 = ROM, 1 = RAM, 2 = constant 0x00, 3 = constant 0xFF. Addresses 0x8000–0x9FFF and 0xC000–0xFFFF select 3.
- R12: `ram_ce` is high only for an address in 0xA000–0xBFFF while RAM is enabled and a RAM bank is selected. `ram_we` equals `cpu_wr & ram_ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| rom_addr | output | 21 | Expanded ROM address |
| ram_addr | output | 15 | Banked RAM address |
| ram_ce | output | 1 | RAM chip enable |
| ram_we | output | 1 | RAM write strobe |
| rd_sel | output | 2 | Read data source select |
| sel_err | output | 1 | Unsupported RAM/clock select value, one-cycle pulse |

## Verification
The assertions assume that the CPU holds `cpu_addr` and `cpu_wdata` steady across the clock edge on which `cpu_wr` is high, and that reset is released between edges. The bench drives every input on the falling edge and drops `cpu_wr` one cycle later, so each write is sampled on exactly one rising edge. Read translation is checked half a cycle after the address settles, and the error pulse is checked on both sides of the following edge.

// File: rtl/bmap_pkg.sv
package bmap_pkg;
    typedef enum logic [1:0] {
        SEL_ROM  = 2'd0,
        SEL_RAM  = 2'd1,
        SEL_ZERO = 2'd2,
        SEL_OPEN = 2'd3
    } rd_sel_e;

    typedef enum logic [2:0] {
        RG_ENABLE,
        RG_ROMBANK,
        RG_RAMSEL,
        RG_LATCH,
        RG_XRAM,
        RG_NONE
    } region_e;
endpackage

// File: rtl/bmap_decode.sv
module bmap_decode
    import bmap_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic              rom_area
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        rom_area = ~addr[TOP];
        unique case (addr[TOP -: 3])
            3'b000:  region = RG_ENABLE;
            3'b001:  region = RG_ROMBANK;
            3'b010:  region = RG_RAMSEL;
            3'b011:  region = RG_LATCH;
            3'b101:  region = RG_XRAM;
            default: region = RG_NONE;
        endcase
    end
endmodule

// File: rtl/bmap_ctrl.sv
module bmap_ctrl
    import bmap_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter int          ROM_BANK_W = 7,
    parameter int          RAM_BANK_W = 2,
    parameter logic [7:0]  EN_CODE    = 8'h0A,
    parameter logic [7:0]  DIS_CODE   = 8'h00,
    parameter logic [7:0]  CLK_LO     = 8'h08,
    parameter logic [7:0]  CLK_HI     = 8'h0C
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  region_e               region,
    input  logic [DATA_W-1:0]     wdata,
    output logic                  ram_en,
    output logic                  clk_sel,
    output logic [ROM_BANK_W-1:0] rom_bank,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output logic                  err
);
    localparam int RAM_BANKS = 1 << RAM_BANK_W;
    localparam logic [DATA_W-1:0] RAM_LIMIT = DATA_W'(RAM_BANKS);

    typedef struct packed {
        logic                  ram_en;
        logic                  clk_sel;
        logic [ROM_BANK_W-1:0] rom_bank;
        logic [RAM_BANK_W-1:0] ram_bank;
        logic                  err;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (wr) begin
            unique case (region)
                RG_ENABLE: begin
                    if (wdata == DATA_W'(EN_CODE))
                        st_d.ram_en = 1'b1;
                    else if (wdata == DATA_W'(DIS_CODE))
                        st_d.ram_en = 1'b0;
                end
                RG_ROMBANK: st_d.rom_bank = wdata[ROM_BANK_W-1:0];
                RG_RAMSEL: begin
                    if (wdata < RAM_LIMIT) begin
                        st_d.ram_bank = wdata[RAM_BANK_W-1:0];
                        st_d.clk_sel  = 1'b0;
                    end else if (wdata >= DATA_W'(CLK_LO) && wdata <= DATA_W'(CLK_HI)) begin
                        st_d.clk_sel  = 1'b1;
                    end else begin
                        st_d.err      = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ram_en   = st_q.ram_en;
    assign clk_sel  = st_q.clk_sel;
    assign rom_bank = st_q.rom_bank;
    assign ram_bank = st_q.ram_bank;
    assign err      = st_q.err;
endmodule

// File: rtl/bmap_xlate.sv
module bmap_xlate
    import bmap_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int ROM_BANK_W = 7,
    parameter int RAM_BANK_W = 2,
    parameter int ROM_WIN_W  = 14,
    parameter int RAM_WIN_W  = 13
) (
    input  logic [ADDR_W-1:0]               addr,
    input  logic                            wr,
    input  region_e                         region,
    input  logic                            rom_area,
    input  logic                            ram_en,
    input  logic                            clk_sel,
    input  logic [ROM_BANK_W-1:0]           rom_bank,
    input  logic [RAM_BANK_W-1:0]           ram_bank,
    output logic [ROM_BANK_W+ROM_WIN_W-1:0] rom_addr,
    output logic [RAM_BANK_W+RAM_WIN_W-1:0] ram_addr,
    output logic                            ram_ce,
    output logic                            ram_we,
    output rd_sel_e                         rd_sel
);
    logic upper_win;
    logic xram_hit;

    always_comb begin
        upper_win = rom_area & addr[ROM_WIN_W];
        xram_hit  = (region == RG_XRAM);

        rom_addr  = {(upper_win ? rom_bank : '0), addr[ROM_WIN_W-1:0]};
        ram_addr  = {ram_bank, addr[RAM_WIN_W-1:0]};

        ram_ce    = xram_hit & ram_en & ~clk_sel;
        ram_we    = ram_ce & wr;

        if (rom_area)      rd_sel = SEL_ROM;
        else if (!xram_hit) rd_sel = SEL_OPEN;
        else if (!ram_en)  rd_sel = SEL_OPEN;
        else if (clk_sel)  rd_sel = SEL_ZERO;
        else               rd_sel = SEL_RAM;
    end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bmap_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int ROM_BANK_W = 7,
    parameter int RAM_BANK_W = 2,
    parameter int ROM_WIN_W  = 14,
    parameter int RAM_WIN_W  = 13,
    localparam int ROM_A_W   = ROM_BANK_W + ROM_WIN_W,
    localparam int RAM_A_W   = RAM_BANK_W + RAM_WIN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic               cpu_wr,
    output logic [ROM_A_W-1:0] rom_addr,
    output logic [RAM_A_W-1:0] ram_addr,
    output logic               ram_ce,
    output logic               ram_we,
    output logic [1:0]         rd_sel,
    output logic               sel_err
);
    region_e                region;
    logic                   rom_area;
    logic                   ram_en;
    logic                   clk_sel;
    logic [ROM_BANK_W-1:0]  rom_bank;
    logic [RAM_BANK_W-1:0]  ram_bank;
    rd_sel_e                sel_e;

    bmap_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr     (cpu_addr),
        .region   (region),
        .rom_area (rom_area)
    );

    bmap_ctrl #(
        .DATA_W     (DATA_W),
        .ROM_BANK_W (ROM_BANK_W),
        .RAM_BANK_W (RAM_BANK_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cpu_wr),
        .region   (region),
        .wdata    (cpu_wdata),
        .ram_en   (ram_en),
        .clk_sel  (clk_sel),
        .rom_bank (rom_bank),
        .ram_bank (ram_bank),
        .err      (sel_err)
    );

    bmap_xlate #(
        .ADDR_W     (ADDR_W),
        .ROM_BANK_W (ROM_BANK_W),
        .RAM_BANK_W (RAM_BANK_W),
        .ROM_WIN_W  (ROM_WIN_W),
        .RAM_WIN_W  (RAM_WIN_W)
    ) u_xlate (
        .addr     (cpu_addr),
        .wr       (cpu_wr),
        .region   (region),
        .rom_area (rom_area),
        .ram_en   (ram_en),
        .clk_sel  (clk_sel),
        .rom_bank (rom_bank),
        .ram_bank (ram_bank),
        .rom_addr (rom_addr),
        .ram_addr (ram_addr),
        .ram_ce   (ram_ce),
        .ram_we   (ram_we),
        .rd_sel   (sel_e)
    );

    assign rd_sel = sel_e;
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
    parameter int ADDR_W  = 16,
    parameter int ROM_A_W = 21,
    parameter int ROM_WIN_W = 14
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  cpu_addr,
    input logic               cpu_wr,
    input logic [ROM_A_W-1:0] rom_addr,
    input logic               ram_ce,
    input logic               ram_we,
    input logic [1:0]         rd_sel,
    input logic               sel_err
);
    localparam int T = ADDR_W - 1;

    // R2: the fixed window never carries a bank number
    assert_low_rom_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[T -: 2] == 2'b00) |-> (rom_addr[ROM_A_W-1:ROM_WIN_W] == '0));

    // R5: the bank bits seen in the upper window only move after a bank write
    assert_bank_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_addr[T -: 2] == 2'b01) && $past(cpu_addr[T -: 2] == 2'b01)
          && !$past(cpu_wr && cpu_addr[T -: 3] == 3'b001))
        |-> $stable(rom_addr[ROM_A_W-1:ROM_WIN_W]));

    // R7: zero-data select never enables the RAM
    assert_zero_noce_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd2) |-> !ram_ce);

    // R8: an error pulse follows a write to the select window
    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err |-> $past(cpu_wr && cpu_addr[T -: 3] == 3'b010));

    // R10: 0xFF data select never enables the RAM
    assert_open_noce_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd3) |-> !ram_ce);

    // R12: write strobe needs chip enable and a CPU write
    assert_we_ce_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_ce && cpu_wr));

    // R12: chip enable only inside the external RAM window
    assert_ce_win_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ram_ce |-> (cpu_addr[T -: 3] == 3'b101));
endmodule

bind bank_mapper bank_mapper_chk #(
    .ADDR_W    (ADDR_W),
    .ROM_A_W   (ROM_A_W),
    .ROM_WIN_W (ROM_WIN_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_wr   (cpu_wr),
    .rom_addr (rom_addr),
    .ram_ce   (ram_ce),
    .ram_we   (ram_we),
    .rd_sel   (rd_sel),
    .sel_err  (sel_err)
);

// File: tb/bank_mapper_tb.sv
`timescale 1ns/1ps
module bank_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic [20:0] rom_addr;
    logic [14:0] ram_addr;
    logic        ram_ce, ram_we, sel_err;
    logic [1:0]  rd_sel;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bank_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .rom_addr(rom_addr), .ram_addr(ram_addr),
        .ram_ce(ram_ce), .ram_we(ram_we), .rd_sel(rd_sel), .sel_err(sel_err)
    );

    // external RAM model: 4 banks x 16 bytes
    logic [7:0] ram_mem [64];
    always @(posedge clk)
        if (ram_we) ram_mem[{ram_addr[14:13], ram_addr[3:0]}] <= cpu_wdata;

    function automatic logic [7:0] rdata();
        case (rd_sel)
            2'd0:    return rom_addr[7:0] ^ {1'b0, rom_addr[20:14]};
            2'd1:    return ram_mem[{ram_addr[14:13], ram_addr[3:0]}];
            2'd2:    return 8'h00;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic set_rd(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_wr = 1'b0;
        #1;
    endtask

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [20:0] rom;
        logic [14:0] ram;
        logic [1:0]  sel;
        logic        ce;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 16'h4123, 8'h00, 21'h000123, 15'h0000, 2'd0, 1'b0, 4'd1},  // R1 bank 0
        '{1'b0, 16'hA005, 8'h00, 21'h0,      15'h0005, 2'd3, 1'b0, 4'd1},  // R1 disabled
        '{1'b0, 16'h1ABC, 8'h00, 21'h001ABC, 15'h0000, 2'd0, 1'b0, 4'd2},  // R2
        '{1'b1, 16'h2100, 8'h85, 21'h0,      15'h0000, 2'd0, 1'b0, 4'd5},  // R5 masked to 05
        '{1'b0, 16'h7FFF, 8'h00, 21'h017FFF, 15'h0000, 2'd0, 1'b0, 4'd5},  // R5
        '{1'b0, 16'h3FFF, 8'h00, 21'h003FFF, 15'h0000, 2'd0, 1'b0, 4'd2},  // R2 bank ignored
        '{1'b1, 16'h0000, 8'h0A, 21'h0,      15'h0000, 2'd0, 1'b0, 4'd4},  // R4 enable
        '{1'b0, 16'hA010, 8'h00, 21'h0,      15'h0010, 2'd1, 1'b1, 4'd4},  // R4
        '{1'b1, 16'h1FFF, 8'h55, 21'h0,      15'h0000, 2'd0, 1'b0, 4'd4},  // R4 other value
        '{1'b0, 16'hBFFF, 8'h00, 21'h0,      15'h1FFF, 2'd1, 1'b1, 4'd4},  // R4 still on
        '{1'b1, 16'h4000, 8'h02, 21'h0,      15'h0000, 2'd0, 1'b0, 4'd6},  // R6 bank 2
        '{1'b0, 16'hA003, 8'h00, 21'h0,      15'h4003, 2'd1, 1'b1, 4'd6},  // R6
        '{1'b1, 16'h6000, 8'h01, 21'h0,      15'h0000, 2'd0, 1'b0, 4'd9},  // R9 latch
        '{1'b0, 16'h7000, 8'h00, 21'h017000, 15'h0000, 2'd0, 1'b0, 4'd9},  // R9
        '{1'b0, 16'hA003, 8'h00, 21'h0,      15'h4003, 2'd1, 1'b1, 4'd9},  // R9
        '{1'b1, 16'h5FFF, 8'h08, 21'h0,      15'h0000, 2'd0, 1'b0, 4'd7},  // R7 low code
        '{1'b0, 16'hA003, 8'h00, 21'h0,      15'h0000, 2'd2, 1'b0, 4'd7},  // R7
        '{1'b1, 16'h4000, 8'h03, 21'h0,      15'h0000, 2'd0, 1'b0, 4'd6},  // R6 bank 3
        '{1'b0, 16'hB001, 8'h00, 21'h0,      15'h7001, 2'd1, 1'b1, 4'd6},  // R6
        '{1'b1, 16'h4000, 8'h0C, 21'h0,      15'h0000, 2'd0, 1'b0, 4'd7},  // R7 high code
        '{1'b0, 16'hBFFE, 8'h00, 21'h0,      15'h0000, 2'd2, 1'b0, 4'd7},  // R7
        '{1'b1, 16'h4000, 8'h00, 21'h0,      15'h0000, 2'd0, 1'b0, 4'd6},  // R6 bank 0
        '{1'b0, 16'hA001, 8'h00, 21'h0,      15'h0001, 2'd1, 1'b1, 4'd6},  // R6
        '{1'b0, 16'h8000, 8'h00, 21'h0,      15'h0000, 2'd3, 1'b0, 4'd11}, // R11
        '{1'b0, 16'hC000, 8'h00, 21'h0,      15'h0000, 2'd3, 1'b0, 4'd11}, // R11
        '{1'b1, 16'h2000, 8'h7F, 21'h0,      15'h0000, 2'd0, 1'b0, 4'd3},  // R3 top bank
        '{1'b0, 16'h4000, 8'h00, 21'h1FC000, 15'h0000, 2'd0, 1'b0, 4'd3},  // R3
        '{1'b1, 16'h0000, 8'h00, 21'h0,      15'h0000, 2'd0, 1'b0, 4'd10}, // R10 disable
        '{1'b0, 16'hA000, 8'h00, 21'h0,      15'h0000, 2'd3, 1'b0, 4'd10}  // R10
    };

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(sel_err == 1'b0, "R1 err", sel_err, 0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                wr_reg(VEC[i].addr, VEC[i].data);
            end else begin
                set_rd(VEC[i].addr);
                chk(rd_sel == VEC[i].sel, $sformatf("R%0d sel v%0d", VEC[i].req, i), rd_sel, VEC[i].sel);
                chk(ram_ce == VEC[i].ce, $sformatf("R%0d ce v%0d", VEC[i].req, i), ram_ce, VEC[i].ce);
                if (VEC[i].sel == 2'd0)
                    chk(rom_addr == VEC[i].rom, $sformatf("R%0d rom v%0d", VEC[i].req, i), rom_addr, VEC[i].rom);
                if (VEC[i].ce)
                    chk(ram_addr == VEC[i].ram, $sformatf("R%0d ram v%0d", VEC[i].req, i), ram_addr, VEC[i].ram);
            end
        end

        // R8: unsupported select values
        wr_reg(16'h0000, 8'h0A);
        wr_reg(16'h4000, 8'h01);
        wr_reg(16'h4000, 8'h05);
        #1;
        chk(sel_err == 1'b1, "R8 pulse", sel_err, 1);
        @(negedge clk); #1;
        chk(sel_err == 1'b0, "R8 one cycle", sel_err, 0);
        wr_reg(16'h4000, 8'h07);
        #1 chk(sel_err == 1'b1, "R8 code 07", sel_err, 1);
        wr_reg(16'h5000, 8'h0D);
        #1 chk(sel_err == 1'b1, "R8 code 0D", sel_err, 1);
        wr_reg(16'h4000, 8'h0B);
        #1 chk(sel_err == 1'b0, "R8 valid clk code", sel_err, 0);
        wr_reg(16'h4000, 8'h01);
        wr_reg(16'h4000, 8'hFF);
        set_rd(16'hA002);
        chk(ram_addr == 15'h2002, "R8 bank kept", ram_addr, 15'h2002);
        chk(rd_sel == 2'd1, "R8 still ram", rd_sel, 1);

        // R12: write strobe and data path through RAM model
        @(negedge clk);
        cpu_addr = 16'hA005; cpu_wdata = 8'h3C; cpu_wr = 1'b1;
        #1 chk(ram_we == 1'b1, "R12 we", ram_we, 1);
        set_rd(16'hA005);
        chk(rdata() == 8'h3C, "R12 readback", rdata(), 8'h3C);
        chk(ram_we == 1'b0, "R12 no wr no we", ram_we, 0);

        // R7: clock space drops writes and reads zero
        wr_reg(16'h4000, 8'h0A);
        @(negedge clk);
        cpu_addr = 16'hA005; cpu_wdata = 8'h99; cpu_wr = 1'b1;
        #1 chk(ram_we == 1'b0, "R7 write dropped", ram_we, 0);
        set_rd(16'hA005);
        chk(rdata() == 8'h00, "R7 read zero", rdata(), 0);
        wr_reg(16'h4000, 8'h01);
        set_rd(16'hA005);
        chk(rdata() == 8'h3C, "R7 ram kept", rdata(), 8'h3C);

        // R10: disabled RAM, no strobe, 0xFF data
        wr_reg(16'h0000, 8'h00);
        @(negedge clk);
        cpu_addr = 16'hA005; cpu_wdata = 8'h77; cpu_wr = 1'b1;
        #1 chk(ram_we == 1'b0, "R10 no we", ram_we, 0);
        set_rd(16'hA005);
        chk(rdata() == 8'hFF, "R10 read FF", rdata(), 8'hFF);
        wr_reg(16'h0000, 8'h0A);
        set_rd(16'hA005);
        chk(rdata() == 8'h3C, "R10 ram kept", rdata(), 8'h3C);

        // R1: reset mid-run restores defaults
        wr_reg(16'h2000, 8'h12);
        wr_reg(16'h4000, 8'h05);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1 chk(sel_err == 1'b0, "R1 err cleared", sel_err, 0);
        set_rd(16'h4001);
        chk(rom_addr == 21'h000001, "R1 rom bank 0", rom_addr, 21'h000001);
        set_rd(16'hA000);
        chk(rd_sel == 2'd3, "R1 ram off", rd_sel, 3);
        chk(ram_ce == 1'b0, "R1 no ce", ram_ce, 0);
        wr_reg(16'h0000, 8'h0A);
        set_rd(16'hA004);
        chk(ram_addr == 15'h0004, "R1 ram bank 0", ram_addr, 15'h0004);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule